// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter with a small register interface guarded by a 16-bit unlock key. Software first writes the key value into the key register. It then chooses what an expiry does (a non-maskable interrupt request or a system reset request), clears the counter, and starts the count by writing a 4-bit run code. Only one run code stops the counter. Every other code lets it count. Writing any other value into the key register locks the configuration again. While the block runs, software must keep clearing the counter. If it fails to, the counter wraps from its all-ones value to zero and the block sends a single-cycle request.

The watchdog clock is modelled as the input `wd_tick`, one pulse per watchdog clock period. It is held low when the watchdog clock source is stopped, for example in a sleep state. A debug-halt input and a debug-run configuration bit together decide whether ticks are ignored while the CPU is halted for debug. While ticks are ignored, every register and the counter keep their values.

A small control state machine tracks the counter. Its states are `ST_IDLE` (run code is the stop code), `ST_COUNT` (counting), `ST_FIRE_NMI` (interrupt request cycle) and `ST_FIRE_RST` (reset request cycle). Its transitions are:
- Start: `ST_IDLE`→`ST_COUNT` once the run code is not the stop code.
- Halt: `ST_COUNT`→`ST_IDLE` once the stop code is back.
- Expire: any state→`ST_FIRE_NMI` or `ST_FIRE_RST` on a wrap, chosen by the select bit.
- Recover: a fire state returns to `ST_COUNT` or `ST_IDLE`, depending on the run code.

Top module: `kwdt_top`

## Requirements
- R1: The control register (address 1) and clock register (address 2) accept bus writes only while the key register (address 0) holds 0x0096. The key register accepts any written value at any time, and any value other than 0x0096 locks the block.
- R2: The run field is control bits [3:0]. When it holds 0xA, the counter holds its value. Any other value, such as 0x0 or 0x5, makes the counter advance by one on every effective tick, starting with ticks after the write.
- R3: Writing 1 to control bit 4 while unlocked clears the counter at that write, and the bit always reads 0. The next expiry comes 2^CNT_W effective ticks after the clear.
- R4: An expiry is the counter stepping from all ones to zero. It raises `rst_req` when control bit 5 is 0, or `nmi_req` when control bit 5 is 1. The request lasts one cycle, starts in the cycle right after the wrapping tick's edge, and the two requests are never high together.
- R5: An expiry that raises `nmi_req` sets control bit 6, and an expiry that raises `rst_req` leaves it unchanged. Writing 1 to control bit 6 clears it, but only while unlocked.
- R6: Clock register bit 0 is the debug-run bit. While `dbg_halt` is 1 and debug-run is 0, ticks are ignored and the counter holds. Counting resumes from the held value when `dbg_halt` falls.
- R7: While debug-run is 1, the counter keeps advancing while `dbg_halt` is 1.
- R8: While `wd_tick` is 0, the counter holds its value.
- R9: After reset, the block reads as follows:
  - key register 0x0000
  - run field 0xA
  - control bits 4, 5 and 6 at 0
  - debug-run 0
  - counter 0
  - both requests low
- R10: Reads return the register selected by `bus_addr`, combinationally. Address 3 returns the counter value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wd_tick | input | 1 | One pulse per watchdog clock period; low while that clock is stopped |
| dbg_halt | input | 1 | CPU halted for debug |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| nmi_req | output | 1 | Single-cycle interrupt request on expiry |
| rst_req | output | 1 | Single-cycle reset request on expiry |

## Verification
A register write takes effect at the edge where `bus_wr` is sampled, and a read is combinational. The bench therefore drives each write at a falling edge and reads the result at the next falling edge. A running counter that has just been cleared shows the value n after n further edges with ticks present. The request is visible on the falling edge after the 2^CNT_W-th edge, so the bench first counts zero requests over 2^CNT_W−1 edges, then expects exactly one request, and then expects it to have dropped one edge later. Hold checks read the counter before and after a window and compare the difference with the number of effective ticks in that window.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int unsigned REG_AW = 2;

    localparam logic [REG_AW-1:0] A_KEY  = 2'd0;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd1;
    localparam logic [REG_AW-1:0] A_CLK  = 2'd2;
    localparam logic [REG_AW-1:0] A_CNT  = 2'd3;

    localparam int unsigned F_RUN_LSB = 0;
    localparam int unsigned F_RUN_W   = 4;
    localparam int unsigned F_CLR     = 4;
    localparam int unsigned F_SEL     = 5;
    localparam int unsigned F_STAT    = 6;
    localparam int unsigned F_DBGRUN  = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FIRE_NMI,
        ST_FIRE_RST
    } wdt_state_e;

    typedef struct packed {
        logic [F_RUN_W-1:0] run;
        logic               sel_nmi;
        logic               dbg_run;
    } wdt_cfg_t;

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int unsigned          DATA_W    = 16,
    parameter int unsigned          CNT_W     = 16,
    parameter logic [DATA_W-1:0]    KEY       = 16'h0096,
    parameter logic [F_RUN_W-1:0]   STOP_CODE = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              nmi_set,
    input  logic [CNT_W-1:0]  cnt_val,
    output wdt_cfg_t          cfg,
    output logic              cnt_clr,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [DATA_W-1:0] key_q;
    logic              unlocked;
    logic              wr_key, wr_ctrl, wr_clk;
    logic              stat_q;
    wdt_cfg_t          cfg_q;

    assign unlocked = (key_q == KEY);
    assign wr_key   = bus_wr && (bus_addr == A_KEY);
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL) && unlocked;
    assign wr_clk   = bus_wr && (bus_addr == A_CLK) && unlocked;
    assign cnt_clr  = wr_ctrl && bus_wdata[F_CLR];
    assign cfg      = cfg_q;

    // key register: always writable
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (wr_key) key_q <= bus_wdata;
    end

    // guarded configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.run     <= STOP_CODE;
            cfg_q.sel_nmi <= 1'b0;
            cfg_q.dbg_run <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cfg_q.run     <= bus_wdata[F_RUN_LSB +: F_RUN_W];
                cfg_q.sel_nmi <= bus_wdata[F_SEL];
            end
            if (wr_clk) cfg_q.dbg_run <= bus_wdata[F_DBGRUN];
        end
    end

    // sticky interrupt status, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                            stat_q <= 1'b0;
        else if (nmi_set)                      stat_q <= 1'b1;
        else if (wr_ctrl && bus_wdata[F_STAT]) stat_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_KEY:  bus_rdata = key_q;
            A_CTRL: begin
                bus_rdata[F_RUN_LSB +: F_RUN_W] = cfg_q.run;
                bus_rdata[F_SEL]                = cfg_q.sel_nmi;
                bus_rdata[F_STAT]               = stat_q;
            end
            A_CLK:  bus_rdata[F_DBGRUN]   = cfg_q.dbg_run;
            A_CNT:  bus_rdata[CNT_W-1:0]  = cnt_val;
        endcase
    end

    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !unlocked && bus_addr != A_KEY) |=> ($stable(cfg_q.run) && $stable(cfg_q.sel_nmi) && $stable(cfg_q.dbg_run))); // R1

    AST_NMI_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_set |=> stat_q); // R5

endmodule

// File: rtl/kwdt_gate.sv
module kwdt_gate (
    input  logic tick,
    input  logic dbg_halt,
    input  logic dbg_run,
    output logic tick_eff
);

    logic frozen;

    // debug freeze unless debug-run is set
    assign frozen   = dbg_halt && !dbg_run;
    assign tick_eff = tick && !frozen;

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int unsigned        CNT_W     = 16,
    parameter logic [F_RUN_W-1:0] STOP_CODE = 4'hA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_eff,
    input  logic [F_RUN_W-1:0] run,
    input  logic               sel_nmi,
    input  logic               cnt_clr,
    output logic [CNT_W-1:0]   cnt_val,
    output logic               nmi_set,
    output logic               nmi_req,
    output logic               rst_req
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             count_en;
    logic             wrap;

    assign count_en = tick_eff && (run != STOP_CODE);
    assign wrap     = count_en && !cnt_clr && (cnt_q == CNT_MAX);
    assign nmi_set  = wrap && sel_nmi;
    assign cnt_val  = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_clr)  cnt_q <= '0;
        else if (count_en) cnt_q <= cnt_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_COUNT, ST_FIRE_NMI, ST_FIRE_RST: begin
                if (wrap)                   state_d = sel_nmi ? ST_FIRE_NMI : ST_FIRE_RST;
                else if (run == STOP_CODE)  state_d = ST_IDLE;
                else                        state_d = ST_COUNT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        nmi_req = 1'b0;
        rst_req = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_COUNT:    ;
            ST_FIRE_NMI: nmi_req = 1'b1;
            ST_FIRE_RST: rst_req = 1'b1;
        endcase
    end

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run == STOP_CODE && !cnt_clr) |=> $stable(cnt_q)); // R2

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_q == '0)); // R3

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_req && rst_req)); // R4

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req || rst_req) |=> !(nmi_req || rst_req)); // R4

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_eff && !cnt_clr) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CNT_W     = 16,
    parameter logic [15:0] KEY       = 16'h0096,
    parameter logic [3:0]  STOP_CODE = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_tick,
    input  logic              dbg_halt,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nmi_req,
    output logic              rst_req
);

    wdt_cfg_t         cfg;
    logic             cnt_clr;
    logic             nmi_set;
    logic             tick_eff;
    logic [CNT_W-1:0] cnt_val;

    kwdt_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY), .STOP_CODE(STOP_CODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .nmi_set(nmi_set), .cnt_val(cnt_val),
        .cfg(cfg), .cnt_clr(cnt_clr), .bus_rdata(bus_rdata)
    );

    kwdt_gate u_gate (
        .tick(wd_tick), .dbg_halt(dbg_halt), .dbg_run(cfg.dbg_run),
        .tick_eff(tick_eff)
    );

    kwdt_core #(
        .CNT_W(CNT_W), .STOP_CODE(STOP_CODE)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick_eff(tick_eff), .run(cfg.run),
        .sel_nmi(cfg.sel_nmi), .cnt_clr(cnt_clr), .cnt_val(cnt_val),
        .nmi_set(nmi_set), .nmi_req(nmi_req), .rst_req(rst_req)
    );

endmodule

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;

    localparam int CW   = 8;
    localparam int FULL = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wd_tick = 1'b1;
    logic        dbg_halt = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        nmi_req, rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    kwdt_top #(.CNT_W(CW)) u_kwdt_top (
        .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .dbg_halt(dbg_halt),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .nmi_req(nmi_req), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic pulses(input int n, output int nn, output int nr);
        nn = 0; nr = 0;
        repeat (n) begin
            step(1);
            nn += int'(nmi_req);
            nr += int'(rst_req);
        end
    endtask

    task automatic t_reset;
        int v;
        rd(2'd0, v); chk("R9 key", v, 0);
        rd(2'd1, v); chk("R9 ctrl", v, 'h000A);
        rd(2'd2, v); chk("R9 clkreg", v, 0);
        rd(2'd3, v); chk("R9 count", v, 0);
        chk("R9 nmi_req", int'(nmi_req), 0);
        chk("R9 rst_req", int'(rst_req), 0);
    endtask

    task automatic t_locked;
        int v;
        wr(2'd1, 16'h0010);
        rd(2'd1, v); chk("R1 locked ctrl write ignored", v, 'h000A);
        wr(2'd2, 16'h0001);
        rd(2'd2, v); chk("R1 locked clk write ignored", v, 0);
        step(5);
        rd(2'd3, v); chk("R2 stopped counter holds", v, 0);
        wr(2'd0, 16'h0096);
        rd(2'd0, v); chk("R1 key readback", v, 'h0096);
    endtask

    task automatic t_reset_expiry;
        int v, nn, nr;
        wr(2'd1, 16'h0010);
        rd(2'd1, v); chk("R3 clear bit reads 0", v, 'h0000);
        rd(2'd3, v); chk("R3 cleared", v, 0);
        pulses(100, nn, nr);
        rd(2'd3, v); chk("R10 count readback", v, 100);
        pulses(FULL - 101, nn, nr);
        chk("R4 no early rst", nr, 0);
        chk("R4 no early nmi", nn, 0);
        step(1);
        chk("R4 rst pulse", int'(rst_req), 1);
        chk("R4 nmi low in reset mode", int'(nmi_req), 0);
        step(1);
        chk("R4 rst one cycle", int'(rst_req), 0);
        rd(2'd1, v); chk("R5 reset expiry leaves status", v, 'h0000);
    endtask

    task automatic t_nmi_expiry;
        int v, nn, nr;
        wr(2'd1, 16'h0030);
        pulses(FULL - 1, nn, nr);
        chk("R4 no early nmi", nn, 0);
        step(1);
        chk("R4 nmi pulse", int'(nmi_req), 1);
        chk("R4 rst low in nmi mode", int'(rst_req), 0);
        rd(2'd1, v); chk("R5 status set", v, 'h0060);
        step(1);
        chk("R4 nmi one cycle", int'(nmi_req), 0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0040);
        rd(2'd1, v); chk("R5 locked clear ignored", v, 'h0060);
        wr(2'd0, 16'h0096);
        wr(2'd1, 16'h0060);
        rd(2'd1, v); chk("R5 status cleared", v, 'h0020);
        wr(2'd1, 16'h001A);
        step(6);
        rd(2'd3, v); chk("R2 stop code holds zero", v, 0);
    endtask

    task automatic t_other_code;
        int v;
        wr(2'd1, 16'h0015);
        step(7);
        rd(2'd3, v); chk("R2 code 0x5 counts", v, 7);
        wr(2'd1, 16'h001A);
    endtask

    task automatic t_debug;
        int v, w;
        wr(2'd1, 16'h0010);
        step(10);
        rd(2'd3, v); chk("R2 running count", v, 10);
        dbg_halt = 1'b1;
        step(10);
        rd(2'd3, w); chk("R6 frozen in debug", w, v);
        rd(2'd1, w); chk("R6 registers held", w, 'h0000);
        dbg_halt = 1'b0;
        step(5);
        rd(2'd3, w); chk("R6 resumes", w, v + 5);
        wr(2'd2, 16'h0001);
        rd(2'd3, v);
        dbg_halt = 1'b1;
        step(7);
        rd(2'd3, w); chk("R7 counts in debug", w, v + 7);
        dbg_halt = 1'b0;
    endtask

    task automatic t_tick_stop;
        int v, w;
        rd(2'd3, v);
        wd_tick = 1'b0;
        step(10);
        rd(2'd3, w); chk("R8 no tick holds", w, v);
        wd_tick = 1'b1;
        step(3);
        rd(2'd3, w); chk("R8 resumes", w, v + 3);
        wr(2'd1, 16'h001A);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_locked;
        t_reset_expiry;
        t_nmi_expiry;
        t_other_code;
        t_debug;
        t_tick_stop;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule